// File: doc/BRIEF.md
# SIMD Floating-Point Exception Priority Resolver

This unit sits beside a packed SIMD floating-point datapath. For each operation the datapath reports, per lane, the raw exception conditions it detected. The resolver settles precedence inside every lane on its own, honours a per-class mask, and folds the surviving flags of all active lanes into a sticky status register. When an unmasked condition survives in any lane, it raises a precise trap request one cycle after the operation. That request carries the class taken from the lowest-numbered lane that trapped.

Within a lane the order, highest first, is as follows. A signalling-NaN invalid comes first. A quiet-NaN operand comes next; it is not an exception, but it silences everything below it. Then the other invalid and divide-by-zero conditions, which share one level. Then denormal operand, then overflow/underflow, and last inexact. A masked winner lets the lane carry on to lower levels. An unmasked winner ends the lane. Software reads and writes the flags and masks through a write port, and that write wins over a same-cycle update. Operations run in either two-lane or four-lane form.

Top module: `simd_fpx_resolver`

## Requirements
- R1: After reset, flags are 0, masks are 6'h3F (all masked), trap_req is 0 and trap_cls is 0.
- R2: Per-lane condition bits are: 0 signalling-NaN invalid, 1 quiet-NaN operand, 2 other invalid, 3 divide-by-zero, 4 denormal, 5 overflow, 6 underflow, 7 inexact. Flag and mask bits are: 0 invalid, 1 denormal, 2 divide-by-zero, 3 overflow, 4 underflow, 5 inexact. Levels are resolved in the order {0}, {1}, {2,3}, {4}, {5,6}, {7}. A level with an unmasked present condition ends the lane, and every present condition of that level still sets its flag. If overflow or underflow is present at its level, a present inexact also sets its flag.
- R3: A quiet-NaN operand sets no flag, raises no trap and suppresses all lower levels in its lane. A masked present condition sets its flag and lets lower levels in that lane be resolved.
- R4: Lanes resolve independently. The flags of all active lanes are ORed into the status register.
- R5: A lane is active only if its lane_en bit is set and either wide_op is 1 or the lane index is below NARROW. Inactive lanes have no effect.
- R6: Flags are sticky. Without a software write, bits only ever go from 0 to 1.
- R7: When sw_we is 1, flags and masks take sw_flags and sw_masks on the next edge. This overrides any same-cycle operation update.
- R8: trap_req pulses in the cycle after an op_valid whose resolution has an unmasked winner, and at no other time. Changing masks alone never traps.
- R9: trap_cls is the flag bit index of the trapping class (0 invalid, 1 denormal, 2 divide-by-zero, 3 overflow, 4 underflow, 5 inexact). It comes from the lowest-numbered trapping lane. Within a level, invalid beats divide-by-zero and overflow beats underflow. trap_cls is 0 when there is no trap.
- R10: The flag of a trapping class is set in the same update that raises the trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation's conditions are present this cycle |
| wide_op | input | 1 | 1: four-lane operation, 0: two-lane operation |
| lane_en | input | LANES | Per-lane enable |
| lane_cond | input | 8*LANES | Condition bits, lane l at [8l+7:8l] |
| sw_we | input | 1 | Software write strobe |
| sw_flags | input | 6 | Flag value to write |
| sw_masks | input | 6 | Mask value to write |
| flags | output | 6 | Sticky status flags |
| masks | output | 6 | Current mask bits (1 = masked) |
| trap_req | output | 1 | Precise trap request pulse |
| trap_cls | output | 3 | Class of the trapping condition |

## Verification
The bench builds the block with LANES=4 and NARROW=2. This makes both the two-lane and the four-lane forms reachable, so conditions placed in upper lanes can be shown to vanish in two-lane form. With four lanes, selection of the lowest trapping lane is exercised when several lanes trap at once. Directed cases cover every precedence level, the quiet-NaN cut-off and the masked fall-through. A long run of mixed random operations, mask writes and flag writes follows, checked cycle by cycle against a behavioural model.

// File: rtl/simd_fpx_resolver.sv
module simd_fpx_resolver #(
  parameter int LANES  = 4,
  parameter int NARROW = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               op_valid,
  input  logic               wide_op,
  input  logic [LANES-1:0]   lane_en,
  input  logic [8*LANES-1:0] lane_cond,
  input  logic               sw_we,
  input  logic [5:0]         sw_flags,
  input  logic [5:0]         sw_masks,
  output logic [5:0]         flags,
  output logic [5:0]         masks,
  output logic               trap_req,
  output logic [2:0]         trap_cls
);
  localparam int CW = 8;
  localparam int RW = 10;

  // returns {trap, class[2:0], flags[5:0]}
  function automatic logic [RW-1:0] resolve(input logic [CW-1:0] c, input logic [5:0] m);
    logic       go, tr;
    logic [2:0] cl;
    logic [5:0] fl;
    go = 1'b1; tr = 1'b0; cl = 3'd0; fl = 6'd0;
    if (c[0]) begin
      fl[0] = 1'b1;
      if (!m[0]) begin tr = 1'b1; cl = 3'd0; go = 1'b0; end
    end
    if (go && c[1]) go = 1'b0;
    if (go && (c[2] || c[3])) begin
      fl[0] = fl[0] | c[2];
      fl[2] = fl[2] | c[3];
      if (c[2] && !m[0])      begin tr = 1'b1; cl = 3'd0; go = 1'b0; end
      else if (c[3] && !m[2]) begin tr = 1'b1; cl = 3'd2; go = 1'b0; end
    end
    if (go && c[4]) begin
      fl[1] = 1'b1;
      if (!m[1]) begin tr = 1'b1; cl = 3'd1; go = 1'b0; end
    end
    if (go && (c[5] || c[6])) begin
      fl[3] = fl[3] | c[5];
      fl[4] = fl[4] | c[6];
      fl[5] = fl[5] | c[7];
      if (c[5] && !m[3])      begin tr = 1'b1; cl = 3'd3; go = 1'b0; end
      else if (c[6] && !m[4]) begin tr = 1'b1; cl = 3'd4; go = 1'b0; end
    end
    if (go && c[7]) begin
      fl[5] = 1'b1;
      if (!m[5]) begin tr = 1'b1; cl = 3'd5; end
    end
    return {tr, cl, fl};
  endfunction

  logic [RW-1:0] res [LANES];
  logic [5:0]    hit_fl;
  logic          hit_tr;
  logic [2:0]    hit_cls;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    wire act = lane_en[g] && (wide_op || (g < NARROW));
    assign res[g] = act ? resolve(lane_cond[g*CW +: CW], masks) : '0;
  end

  always_comb begin
    hit_fl  = '0;
    hit_tr  = 1'b0;
    hit_cls = '0;
    for (int l = LANES-1; l >= 0; l--) begin
      hit_fl = hit_fl | res[l][5:0];
      if (res[l][RW-1]) begin
        hit_tr  = 1'b1;
        hit_cls = res[l][8:6];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags    <= '0;
      masks    <= '1;
      trap_req <= 1'b0;
      trap_cls <= '0;
    end else begin
      trap_req <= op_valid && hit_tr;
      trap_cls <= (op_valid && hit_tr) ? hit_cls : 3'd0;
      if (sw_we) begin
        flags <= sw_flags;
        masks <= sw_masks;
      end else if (op_valid) begin
        flags <= flags | hit_fl;
      end
    end
  end

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(sw_we)) |-> ((flags & $past(flags)) == $past(flags)));

  p_sw_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(sw_we)) |-> (flags == $past(sw_flags) && masks == $past(sw_masks)));

  p_trap_needs_op_r8: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> ($past(rst_n) && $past(op_valid)));

  p_cls_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req |-> trap_cls <= 3'd5) and (!trap_req |-> trap_cls == 3'd0));

  p_trap_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && !$past(sw_we)) |-> (((flags >> trap_cls) & 6'd1) != 6'd0));
endmodule

// File: tb/test_simd_fpx_resolver.sv
module test_simd_fpx_resolver;
  localparam int PERIOD = 10;
  localparam int LANES  = 4;
  localparam int NARROW = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0, wide_op = 1'b0, sw_we = 1'b0;
  logic [3:0]  lane_en = '0;
  logic [31:0] lane_cond = '0;
  logic [5:0]  sw_flags = '0, sw_masks = '0;
  logic [5:0]  flags, masks;
  logic        trap_req;
  logic [2:0]  trap_cls;

  int checks = 0, errors = 0;
  logic [5:0] e_fl, e_mk;
  logic       e_tr;
  int         e_cls;

  always #(PERIOD/2) clk = ~clk;

  simd_fpx_resolver #(.LANES(LANES), .NARROW(NARROW)) i_simd_fpx_resolver (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .wide_op(wide_op),
    .lane_en(lane_en), .lane_cond(lane_cond), .sw_we(sw_we),
    .sw_flags(sw_flags), .sw_masks(sw_masks), .flags(flags), .masks(masks),
    .trap_req(trap_req), .trap_cls(trap_cls));

  function automatic int flag_of(int b);
    case (b)
      0: return 0;  1: return -1; 2: return 0; 3: return 2;
      4: return 1;  5: return 3;  6: return 4; default: return 5;
    endcase
  endfunction

  function automatic int level_of(int b);
    case (b)
      0: return 1; 1: return 2; 2, 3: return 3;
      4: return 4; 5, 6: return 5; default: return 6;
    endcase
  endfunction

  task automatic lane_model(input logic [7:0] c, input logic [5:0] m,
                            output logic [5:0] fl, output logic tr, output int cls);
    bit stop;
    stop = 0; fl = '0; tr = 0; cls = 0;
    for (int lv = 1; lv <= 6; lv++) begin
      bit hit;
      hit = 0;
      if (!stop) begin
        for (int b = 0; b < 8; b++) begin
          if (level_of(b) == lv && c[b]) begin
            hit = 1;
            if (flag_of(b) < 0) stop = 1;
            else begin
              fl[flag_of(b)] = 1'b1;
              if (!m[flag_of(b)] && !tr) begin tr = 1; cls = flag_of(b); stop = 1; end
            end
          end
        end
        if (lv == 5 && hit && c[7]) fl[5] = 1'b1;
      end
    end
  endtask

  task automatic check(input string tag);
    checks++;
    if (flags !== e_fl || masks !== e_mk || trap_req !== e_tr || trap_cls !== 3'(e_cls)) begin
      errors++;
      $display("FAIL %s: flags=%h masks=%h trap=%0d cls=%0d expected flags=%h masks=%h trap=%0d cls=%0d",
               tag, flags, masks, trap_req, trap_cls, e_fl, e_mk, e_tr, e_cls);
    end
  endtask

  task automatic step(input string tag, input bit v, input bit w, input logic [3:0] en,
                      input logic [31:0] cond, input bit we,
                      input logic [5:0] wf, input logic [5:0] wm);
    logic [5:0] acc, lf;
    logic lt, any_t;
    int lc, tc;
    @(negedge clk);
    op_valid = v; wide_op = w; lane_en = en; lane_cond = cond;
    sw_we = we; sw_flags = wf; sw_masks = wm;
    acc = '0; any_t = 0; tc = 0;
    for (int l = 0; l < LANES; l++) begin
      if (en[l] && (w || l < NARROW)) begin
        lane_model(cond[l*8 +: 8], e_mk, lf, lt, lc);
        acc |= lf;
        if (lt && !any_t) begin any_t = 1; tc = lc; end
      end
    end
    e_tr  = v && any_t;
    e_cls = e_tr ? tc : 0;
    if (we) begin e_fl = wf; e_mk = wm; end
    else if (v) e_fl = e_fl | acc;
    @(posedge clk); #1;
    check(tag);
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    e_fl = '0; e_mk = 6'h3F; e_tr = 0; e_cls = 0;
    repeat (3) @(negedge clk);
    check("R1 reset");
    rst_n = 1'b1;
    // R7: unmask all, and a same-cycle op loses to the write
    step("R7 write beats op", 1, 1, 4'hF, 32'h0101_0101, 1, 6'h00, 6'h00);
    // R2: snan invalid over divide-by-zero, trap class 0
    step("R2 snan over dz", 1, 0, 4'b0001, 32'h09, 0, 0, 0);
    step("R7 clear", 0, 0, 0, 0, 1, 6'h00, 6'h00);
    // R3: quiet NaN hides divide-by-zero
    step("R3 qnan cut", 1, 0, 4'b0001, 32'h0A, 0, 0, 0);
    // R3: masked invalid falls through to unmasked denormal
    step("R3 mask invalid", 0, 0, 0, 0, 1, 6'h00, 6'h01);
    step("R3 fall through", 1, 0, 4'b0001, 32'h11, 0, 0, 0);
    // R2: overflow with inexact, class 3, both flags
    step("R2 clear", 0, 0, 0, 0, 1, 6'h00, 6'h00);
    step("R2 ovf+pe", 1, 0, 4'b0001, 32'hE0, 0, 0, 0);
    // R4/R9: lane0 inexact, lane1 divide-by-zero; class from lane 0
    step("R4 clear", 0, 0, 0, 0, 1, 6'h00, 6'h00);
    step("R9 lowest lane", 1, 1, 4'b0011, 32'h0000_0880, 0, 0, 0);
    // R9: lane1 dz and lane3 underflow in four-lane form
    step("R9 clear", 0, 0, 0, 0, 1, 6'h00, 6'h00);
    step("R9 lane1 wins", 1, 1, 4'b1010, 32'h4000_0800, 0, 0, 0);
    // R5: two-lane form ignores lanes 2,3; disabled lanes ignored
    step("R5 clear", 0, 0, 0, 0, 1, 6'h00, 6'h00);
    step("R5 narrow", 1, 0, 4'b1100, 32'h8080_0000, 0, 0, 0);
    step("R5 disabled", 1, 1, 4'b0101, 32'h0008_0008 << 8, 0, 0, 0);
    // R6: sticky across idle cycles
    step("R6 set", 1, 0, 4'b0001, 32'h40, 0, 0, 0);
    step("R6 idle", 0, 0, 0, 0, 0, 0, 0);
    step("R6 idle2", 0, 1, 4'hF, 32'hFFFF_FFFF, 0, 0, 0);
    // R8: masked conditions set flags, later unmask: no trap
    step("R8 maskall", 0, 0, 0, 0, 1, 6'h00, 6'h3F);
    step("R8 masked op", 1, 1, 4'hF, 32'h8040_2010, 0, 0, 0);
    step("R8 unmask", 0, 0, 0, 0, 1, 6'h3F, 6'h00);
    step("R8 quiet", 0, 0, 0, 0, 0, 0, 0);
    // R10: underflow beats inexact under overflow-less level 5
    step("R10 unf", 1, 0, 4'b0010, 32'h0000_C000, 0, 0, 0);
    for (int i = 0; i < 400; i++) begin
      logic [31:0] c;
      int r;
      c = $urandom;
      r = $urandom_range(0, 9);
      if (r == 0) step("R7 random write", $urandom_range(0, 1), $urandom_range(0, 1),
                       4'($urandom), c, 1, 6'($urandom), 6'($urandom));
      else step("R4 random op", r > 2, $urandom_range(0, 1), 4'($urandom), c, 0, 0, 0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule